// File: doc/BRIEF.md
# Byte-Enabled Data Value Comparator

This block qualifies a data value seen on a debug data path. It compares a data word against a programmed compare word one byte lane at a time. A byte-enable mask selects which lanes take part. A two-bit mode then reduces the per-lane results to one match qualifier.

The mode offers three reductions: every enabled lane matches, any enabled lane matches, or either of two lane pairs fully matches. The qualifier is available combinationally on `match_o`. A registered copy, `match_q_o`, gives a one-cycle pulse for every valid data beat that satisfies the selected mode.

Address generation, interrupt decisions and software register decoding belong to the surrounding debug logic, not to this block.

Top module: `dvc_match_top`

## Requirements
- R1: Byte lane i occupies data bits [DATA_W-1-8i -: 8], so byte 0 is the most significant byte. Bit `byte_en_i[i]` enables lane i. A lane matches only when all 8 of its bits equal the same lane of `cmp_val_i`.
- R2: Mode 2'b00 (off) never produces a match.
- R3: An all-zero byte-enable mask never produces a match, in any mode.
- R4: Mode 2'b01 (all) matches when every enabled lane matches. Disabled lanes count as matching.
- R5: Mode 2'b10 (any) matches when at least one enabled lane matches. Disabled lanes count as not matching.
- R6: Mode 2'b11 (pairs) matches when (lane0 AND lane1) OR (lane2 AND lane3) holds.
- R7: In pairs mode, a pair takes part only if at least one of its two lanes is enabled. A disabled lane inside a pair that takes part counts as matching.
- R8: `match_o` follows the inputs combinationally and does not depend on `valid_i`.
- R9: `match_q_o` is high for exactly the one cycle after a clock edge at which `valid_i` was high and the inputs satisfied the mode. It is low in every other cycle.
- R10: While `rst_ni` is low, `match_q_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | DATA_W | Data value under test |
| valid_i | input | 1 | Data beat strobe |
| cmp_val_i | input | DATA_W | Programmed compare value |
| byte_en_i | input | BYTES | Lane enable mask, bit i for lane i |
| mode_i | input | 2 | 00 off, 01 all, 10 any, 11 pairs |
| match_o | output | 1 | Combinational match qualifier |
| match_q_o | output | 1 | Registered one-cycle match pulse |

## Verification
The bench targets the enable mask's effect in each reduction. If disabled lanes were treated the same way in the "all" and "any" modes, sparse masks would give false hits or missed hits. In pairs mode it places a mismatching disabled lane inside an enabled pair, and a matching pair next to a fully disabled one. A design that let a disabled pair contribute, or that demanded a match on a disabled lane, would then flip the result. It also drives an all-zero mask, mode off and beats without the strobe. An off-by-one output register would show up as a pulse one cycle early or late, or as a pulse lasting two cycles.

// File: rtl/dvc_match_pkg.sv
package dvc_match_pkg;
   typedef enum logic [1:0] {
      MODE_OFF   = 2'b00,
      MODE_ALL   = 2'b01,
      MODE_ANY   = 2'b10,
      MODE_PAIRS = 2'b11
   } dvc_mode_e;
endpackage

// File: rtl/dvc_lane_cmp.sv
module dvc_lane_cmp #(
   parameter int BYTES  = 4,
   parameter int BYTE_W = 8,
   localparam int DATA_W = BYTES * BYTE_W
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [DATA_W-1:0] cmp_i,
   output logic [BYTES-1:0]  lane_eq_o
);
   // lane 0 is the most significant byte
   for (genvar i = 0; i < BYTES; i++) begin : g_lane
      localparam int HI = DATA_W - 1 - i * BYTE_W;
      assign lane_eq_o[i] = (data_i[HI -: BYTE_W] == cmp_i[HI -: BYTE_W]);
   end
endmodule

// File: rtl/dvc_combine.sv
module dvc_combine
   import dvc_match_pkg::*;
#(
   parameter int BYTES    = 4,
   parameter bit PAIRS_EN = 1'b1,
   localparam int NPAIR   = BYTES / 2
) (
   input  logic [BYTES-1:0] lane_eq_i,
   input  logic [BYTES-1:0] lane_en_i,
   input  dvc_mode_e        mode_i,
   output logic             hit_o
);
   logic [BYTES-1:0] pass_and;   // disabled lanes pass
   logic [BYTES-1:0] pass_or;    // disabled lanes fail
   logic             all_hit;
   logic             any_hit;
   logic             pair_hit;

   assign pass_and = lane_eq_i | ~lane_en_i;
   assign pass_or  = lane_eq_i & lane_en_i;
   assign all_hit  = (|lane_en_i) & (&pass_and);
   assign any_hit  = |pass_or;

   if (PAIRS_EN) begin : g_pairs
      logic [NPAIR-1:0] grp_hit;
      for (genvar k = 0; k < NPAIR; k++) begin : g_grp
         assign grp_hit[k] = (lane_en_i[2*k] | lane_en_i[2*k+1])
                           & pass_and[2*k] & pass_and[2*k+1];
      end
      assign pair_hit = |grp_hit;
   end else begin : g_no_pairs
      assign pair_hit = 1'b0;
   end

   always_comb begin
      unique case (mode_i)
         MODE_ALL:   hit_o = all_hit;
         MODE_ANY:   hit_o = any_hit;
         MODE_PAIRS: hit_o = pair_hit;
         default:    hit_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/dvc_match_top.sv
module dvc_match_top
   import dvc_match_pkg::*;
#(
   parameter int BYTES    = 4,
   parameter int BYTE_W   = 8,
   parameter bit PAIRS_EN = 1'b1,
   localparam int DATA_W  = BYTES * BYTE_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [DATA_W-1:0] data_i,
   input  logic              valid_i,
   input  logic [DATA_W-1:0] cmp_val_i,
   input  logic [BYTES-1:0]  byte_en_i,
   input  logic [1:0]        mode_i,
   output logic              match_o,
   output logic              match_q_o
);
   if (BYTES < 2 || (BYTES % 2) != 0) begin : g_bad_bytes
      $error("dvc_match_top: BYTES must be an even number of at least 2");
   end
   if (BYTE_W < 1) begin : g_bad_width
      $error("dvc_match_top: BYTE_W must be positive");
   end

   logic [BYTES-1:0] lane_eq;
   dvc_mode_e        mode;

   assign mode = dvc_mode_e'(mode_i);

   dvc_lane_cmp #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_lanes (
      .data_i   (data_i),
      .cmp_i    (cmp_val_i),
      .lane_eq_o(lane_eq)
   );

   dvc_combine #(.BYTES(BYTES), .PAIRS_EN(PAIRS_EN)) u_comb (
      .lane_eq_i(lane_eq),
      .lane_en_i(byte_en_i),
      .mode_i   (mode),
      .hit_o    (match_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) match_q_o <= 1'b0;
      else         match_q_o <= valid_i & match_o;
   end
endmodule

// File: rtl/dvc_match_chk.sv
module dvc_match_chk #(
   parameter int BYTES  = 4,
   parameter int DATA_W = 32
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [DATA_W-1:0] data_i,
   input logic              valid_i,
   input logic [DATA_W-1:0] cmp_val_i,
   input logic [BYTES-1:0]  byte_en_i,
   input logic [1:0]        mode_i,
   input logic              match_o,
   input logic              match_q_o
);
   assert_mode_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == 2'b00) |-> !match_o);

   assert_no_lanes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (byte_en_i == '0) |-> !match_o);

   assert_all_equal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == 2'b01 && byte_en_i != '0 && data_i == cmp_val_i) |-> match_o);

   assert_pulse_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && match_o) |=> match_q_o);

   assert_pulse_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(valid_i && match_o) |=> !match_q_o);
endmodule

bind dvc_match_top dvc_match_chk #(.BYTES(BYTES), .DATA_W(DATA_W)) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .data_i   (data_i),
   .valid_i  (valid_i),
   .cmp_val_i(cmp_val_i),
   .byte_en_i(byte_en_i),
   .mode_i   (mode_i),
   .match_o  (match_o),
   .match_q_o(match_q_o)
);

// File: tb/dvc_match_top_tb_top.sv
module dvc_match_top_tb_top;
   localparam int NB = 4;
   localparam int BW = 8;
   localparam int DW = NB * BW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [DW-1:0] data;
   logic          valid;
   logic [DW-1:0] cmpv;
   logic [NB-1:0] be;
   logic [1:0]    mode;
   logic          match;
   logic          match_q;

   int checks = 0;
   int fails  = 0;
   bit exp_q  = 1'b0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   dvc_match_top dut_i (
      .clk_i(clk), .rst_ni(rst_n), .data_i(data), .valid_i(valid),
      .cmp_val_i(cmpv), .byte_en_i(be), .mode_i(mode),
      .match_o(match), .match_q_o(match_q)
   );

   function automatic bit lane_same(logic [DW-1:0] a, logic [DW-1:0] b, int i);
      int sh = BW * (NB - 1 - i);
      return ((a >> sh) & 8'hFF) == ((b >> sh) & 8'hFF);
   endfunction

   function automatic bit ref_hit(logic [DW-1:0] d, logic [DW-1:0] c,
                                  logic [NB-1:0] en, logic [1:0] m);
      bit r;
      if (m == 2'b00 || en == '0) return 1'b0;
      if (m == 2'b01) begin
         r = 1'b1;
         for (int i = 0; i < NB; i++) if (en[i] && !lane_same(d, c, i)) r = 1'b0;
      end else if (m == 2'b10) begin
         r = 1'b0;
         for (int i = 0; i < NB; i++) if (en[i] && lane_same(d, c, i)) r = 1'b1;
      end else begin
         r = 1'b0;
         for (int k = 0; k < NB / 2; k++) begin
            bit ok = en[2*k] || en[2*k+1];
            for (int j = 2*k; j < 2*k + 2; j++) if (en[j] && !lane_same(d, c, j)) ok = 1'b0;
            if (ok) r = 1'b1;
         end
      end
      return r;
   endfunction

   task automatic check(string req, string what, bit act, bit exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
      end
   endtask

   // one cycle: check registered pulse, drive new inputs, check combinational result
   task automatic step(logic [DW-1:0] d, bit v, logic [DW-1:0] c,
                       logic [NB-1:0] en, logic [1:0] m, string req);
      bit e;
      @(negedge clk);
      check("R9", "match_q_o", match_q, exp_q);
      data = d; valid = v; cmpv = c; be = en; mode = m;
      #1;
      e = ref_hit(d, c, en, m);
      check(req, "match_o", match, e);
      exp_q = v & e;
   endtask

   function automatic string mode_req(logic [1:0] m, logic [NB-1:0] en);
      if (m == 2'b00) return "R2";
      if (en == '0)   return "R3";
      if (m == 2'b01) return "R4";
      if (m == 2'b10) return "R5";
      return "R6";
   endfunction

   initial begin
      #(200000 * 8);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] c, d;
      rst_n = 1'b0;
      data = 32'hA1B2C3D4; cmpv = 32'hA1B2C3D4; be = 4'hF; mode = 2'b01; valid = 1'b1;
      repeat (3) begin
         @(negedge clk);
         check("R10", "match_q_o in reset", match_q, 1'b0);
      end
      valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      exp_q = 1'b0;

      c = 32'h11223344;
      // R1 lane placement: lane 0 is the top byte
      step(32'h11FFFFFF, 1, c, 4'b0001, 2'b01, "R1");
      step(32'hFFFFFF44, 1, c, 4'b1000, 2'b01, "R1");
      step(32'hFF223344, 1, c, 4'b0001, 2'b01, "R1");
      step(32'h11223345, 1, c, 4'b1111, 2'b01, "R1");
      // R2 mode off with full equality
      step(c, 1, c, 4'b1111, 2'b00, "R2");
      // R3 empty mask in every mode
      step(c, 1, c, 4'b0000, 2'b01, "R3");
      step(c, 1, c, 4'b0000, 2'b10, "R3");
      step(c, 1, c, 4'b0000, 2'b11, "R3");
      // R4 disabled lane mismatching is ignored
      step(32'h1122FF44, 1, c, 4'b1011, 2'b01, "R4");
      step(32'h1122FF44, 1, c, 4'b1111, 2'b01, "R4");
      // R5 disabled matching lane does not count
      step(32'h11FFFFFF, 1, c, 4'b1110, 2'b10, "R5");
      step(32'h11FFFFFF, 1, c, 4'b0001, 2'b10, "R5");
      // R6 pair combinations
      step(32'h1122FFFF, 1, c, 4'b1111, 2'b11, "R6");
      step(32'hFFFF3344, 1, c, 4'b1111, 2'b11, "R6");
      step(32'h11FF33FF, 1, c, 4'b1111, 2'b11, "R6");
      // R7 disabled lane in an enabled pair passes; unenabled pair does not
      step(32'h11FFFFFF, 1, c, 4'b0001, 2'b11, "R7");
      step(32'hFFFF33FF, 1, c, 4'b0100, 2'b11, "R7");
      step(32'h1122FFFF, 1, c, 4'b1100, 2'b11, "R7");
      // R8 / R9 match without strobe, then back-to-back strobes
      step(c, 0, c, 4'b1111, 2'b01, "R8");
      step(c, 1, c, 4'b1111, 2'b01, "R9");
      step(c, 1, c, 4'b1111, 2'b01, "R9");
      step(c, 0, c, 4'b1111, 2'b01, "R9");
      step(c, 0, c, 4'b1111, 2'b01, "R9");

      for (int n = 0; n < 3000; n++) begin
         logic [NB-1:0] en;
         logic [1:0]    m;
         c  = $urandom;
         d  = c;
         for (int i = 0; i < NB; i++)
            if ($urandom_range(0, 2) == 0) d[DW-1-BW*i -: BW] = d[DW-1-BW*i -: BW] ^ 8'($urandom_range(1, 255));
         en = NB'($urandom);
         m  = 2'($urandom);
         step(d, 1'($urandom), c, en, m, mode_req(m, en));
      end
      step(c, 0, c, 4'b0000, 2'b00, "R2");
      @(negedge clk);
      check("R9", "match_q_o", match_q, exp_q);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule